// File: doc/BRIEF.md
# Slow-Tick Synchronized Register Write Port

This block is the bus-facing register front end of a low-frequency timekeeping peripheral. The interrupt-enable, time, alarm and stopwatch registers are synced registers. A bus write to one of them is held in a single holding slot and applied only when the next slow tick arrives. While that held write waits, the block drops any further synced write without a trace. Software therefore has to poll the pending flag before it writes again.

The status register works differently. It carries event flags, a live pending flag and a completion flag. Software clears its flags by writing ones, and the clear takes effect on the next bus clock edge, with no tick involved. A prescale-enable register picks which tick strobe performs commits. Both tick strobes arrive as single-cycle enables in the bus clock domain. The time counter is not kept here. Its committed writes leave through a commit port, and reads of the time address return the counter's live value.

Top module: `rtc_wsync_port`

## Requirements
- R1: After reset the status (address 0), interrupt enable (1), alarm (3) and stopwatch (4) registers read 0. The prescale enable (5) reads 1. irq_o is 0 and no commit is pending.
- R2: A write to address 1, 2, 3 or 4 is accepted when no write is pending. Bit 14 of the status register then reads 1 from the next cycle. Readback of the target register keeps its old committed value until the commit.
- R3: A held write is committed at the first selected tick that arrives on a clock edge after the edge that accepted it. A tick on the accepting edge does not commit it. On the commit edge, commit_valid_o pulses for one cycle with commit_sel_o set to the address and commit_data_o set to the data. On the same edge status bit 14 clears, status bit 15 (write complete) sets, and readback shows the new value.
- R4: A synced write that arrives while a write is pending is discarded. It changes neither the held value nor the later commit.
- R5: A write to address 0 clears, on that edge, every status bit among 15 and 0..NEVT-1 whose write-data bit is 1. Bit 14 is not affected by status writes. An event or completion that sets a bit on the same edge wins over the clear.
- R6: A pulse on evt_i[k] sets status bit k.
- R7: irq_o is 1 exactly when some status bit 15 or 0..NEVT-1 is 1 and its interrupt-enable bit at the same position is also 1. The pending bit never raises irq_o.
- R8: A write to address 5 sets the prescale enable from wdata_i[0] at once. When the enable is 1 only tick_sec_i commits. When it is 0 only tick_raw_i commits. The other strobe is ignored.
- R9: Reads of address 2 return cnt_time_i. A write to address 2 reaches the counter only through the commit port.
- R10: Writes to addresses 6 and 7 are ignored and set no pending write. Reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 3 | Register address for read and write |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe, one write per cycle high |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Interrupt request |
| tick_raw_i | input | 1 | Raw oscillator tick enable pulse |
| tick_sec_i | input | 1 | Prescaled one-second tick enable pulse |
| evt_i | input | 7 | Event pulses that set status bits 6..0 |
| cnt_time_i | input | 32 | Live value of the external time counter |
| commit_valid_o | output | 1 | One-cycle pulse for a committed write |
| commit_sel_o | output | 3 | Address of the committed register |
| commit_data_o | output | 32 | Data of the committed write |

## Verification
The assertions check, on every cycle, that:
- a commit pulse lasts one cycle, clears the pending flag and leaves the completion flag set;
- a held write stays untouched while no tick fires;
- the completion flag rises only on a commit;
- irq_o stays low whenever no interrupt is enabled.

Some behaviour only the bench scenarios can show:
- a second write is dropped, not merely delayed;
- the wrong tick strobe is ignored under each prescale setting;
- a tick on the accepting edge does not commit;
- an event wins over a same-edge clear;
- reads of the time address follow the external counter after a commit.

// File: rtl/rtcwp_pkg.sv
package rtcwp_pkg;
    localparam int ADDR_W   = 3;
    localparam int STAT_W   = 16;
    localparam int BIT_DONE = 15;
    localparam int BIT_PEND = 14;

    typedef enum logic [ADDR_W-1:0] {
        A_STAT = 3'd0,
        A_IEN  = 3'd1,
        A_TIME = 3'd2,
        A_ALRM = 3'd3,
        A_SWCH = 3'd4,
        A_PSC  = 3'd5
    } reg_addr_e;

    function automatic logic is_synced(logic [ADDR_W-1:0] a);
        return (a == A_IEN) || (a == A_TIME) || (a == A_ALRM) || (a == A_SWCH);
    endfunction
endpackage

// File: rtl/rtcwp_tick_sel.sv
module rtcwp_tick_sel (
    input  logic psc_en_i,
    input  logic tick_raw_i,
    input  logic tick_sec_i,
    output logic tick_o
);
    always_comb begin
        tick_o = psc_en_i ? tick_sec_i : tick_raw_i;
    end
endmodule

// File: rtl/rtcwp_sync_hold.sv
module rtcwp_sync_hold #(
    parameter int DW = 32,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic [AW-1:0] req_sel_i,
    input  logic [DW-1:0] req_data_i,
    input  logic          tick_i,
    output logic          pend_o,
    output logic          fire_o,
    output logic [AW-1:0] hold_sel_o,
    output logic [DW-1:0] hold_data_o,
    output logic          cv_o,
    output logic [AW-1:0] csel_o,
    output logic [DW-1:0] cdata_o
);
    typedef struct packed {
        logic          pend;
        logic [AW-1:0] sel;
        logic [DW-1:0] data;
        logic          cv;
        logic [AW-1:0] csel;
        logic [DW-1:0] cdata;
    } hold_t;

    hold_t st_d, st_q;
    logic  fire;

    always_comb begin
        st_d    = st_q;
        st_d.cv = 1'b0;
        fire    = st_q.pend & tick_i;
        if (fire) begin
            st_d.pend  = 1'b0;
            st_d.cv    = 1'b1;
            st_d.csel  = st_q.sel;
            st_d.cdata = st_q.data;
        end else if (req_i && !st_q.pend) begin
            st_d.pend = 1'b1;
            st_d.sel  = req_sel_i;
            st_d.data = req_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o      = st_q.pend;
    assign fire_o      = fire;
    assign hold_sel_o  = st_q.sel;
    assign hold_data_o = st_q.data;
    assign cv_o        = st_q.cv;
    assign csel_o      = st_q.csel;
    assign cdata_o     = st_q.cdata;
endmodule

// File: rtl/rtcwp_status.sv
module rtcwp_status #(
    parameter int NEVT = 7,
    parameter int SW   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fire_i,
    input  logic [NEVT-1:0] evt_i,
    input  logic            clr_en_i,
    input  logic [SW-1:0]   clr_data_i,
    input  logic [SW-1:0]   ien_i,
    output logic [SW-1:0]   flags_o,
    output logic            irq_o
);
    import rtcwp_pkg::*;

    localparam logic [SW-1:0] FLAG_MASK =
        (SW'(1) << BIT_DONE) | ((SW'(1) << NEVT) - SW'(1));

    typedef struct packed {
        logic [SW-1:0] flags;
    } stat_t;

    stat_t         st_d, st_q;
    logic [SW-1:0] set_v;

    always_comb begin
        st_d  = st_q;
        set_v = '0;
        set_v[NEVT-1:0] = evt_i;
        set_v[BIT_DONE] = fire_i;
        if (clr_en_i) st_d.flags = st_d.flags & ~(clr_data_i & FLAG_MASK);
        st_d.flags = (st_d.flags | set_v) & FLAG_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;
    assign irq_o   = |(st_q.flags & ien_i & FLAG_MASK);
endmodule

// File: rtl/rtcwp_shadow.sv
module rtcwp_shadow #(
    parameter int DW = 32,
    parameter int AW = 3,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire_i,
    input  logic [AW-1:0] fire_sel_i,
    input  logic [DW-1:0] fire_data_i,
    input  logic          psc_wr_i,
    input  logic          psc_val_i,
    output logic [SW-1:0] ien_o,
    output logic [DW-1:0] alarm_o,
    output logic [DW-1:0] swatch_o,
    output logic          psc_o
);
    import rtcwp_pkg::*;

    typedef struct packed {
        logic [SW-1:0] ien;
        logic [DW-1:0] alarm;
        logic [DW-1:0] swatch;
        logic          psc;
    } shadow_t;

    shadow_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire_i) begin
            case (fire_sel_i)
                A_IEN:   st_d.ien    = fire_data_i[SW-1:0];
                A_ALRM:  st_d.alarm  = fire_data_i;
                A_SWCH:  st_d.swatch = fire_data_i;
                default: st_d.ien    = st_q.ien;
            endcase
        end
        if (psc_wr_i) st_d.psc = psc_val_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.psc <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ien_o    = st_q.ien;
    assign alarm_o  = st_q.alarm;
    assign swatch_o = st_q.swatch;
    assign psc_o    = st_q.psc;
endmodule

// File: rtl/rtc_wsync_port.sv
module rtc_wsync_port #(
    parameter int DW   = 32,
    parameter int NEVT = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [rtcwp_pkg::ADDR_W-1:0] addr_i,
    input  logic [DW-1:0]             wdata_i,
    input  logic                      wr_i,
    output logic [DW-1:0]             rdata_o,
    output logic                      irq_o,
    input  logic                      tick_raw_i,
    input  logic                      tick_sec_i,
    input  logic [NEVT-1:0]           evt_i,
    input  logic [DW-1:0]             cnt_time_i,
    output logic                      commit_valid_o,
    output logic [rtcwp_pkg::ADDR_W-1:0] commit_sel_o,
    output logic [DW-1:0]             commit_data_o
);
    import rtcwp_pkg::*;

    localparam int AW = ADDR_W;
    localparam int SW = STAT_W;

    logic          tick, pend, fire, req, clr_en, psc_wr, psc;
    logic [AW-1:0] hold_sel;
    logic [DW-1:0] hold_data, alarm, swatch;
    logic [SW-1:0] ien, flags, stat_rd;

    always_comb begin
        req    = wr_i && is_synced(addr_i);
        clr_en = wr_i && (addr_i == A_STAT);
        psc_wr = wr_i && (addr_i == A_PSC);
    end

    rtcwp_tick_sel u_tick (
        .psc_en_i  (psc),
        .tick_raw_i(tick_raw_i),
        .tick_sec_i(tick_sec_i),
        .tick_o    (tick)
    );

    rtcwp_sync_hold #(.DW(DW), .AW(AW)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req),
        .req_sel_i  (addr_i),
        .req_data_i (wdata_i),
        .tick_i     (tick),
        .pend_o     (pend),
        .fire_o     (fire),
        .hold_sel_o (hold_sel),
        .hold_data_o(hold_data),
        .cv_o       (commit_valid_o),
        .csel_o     (commit_sel_o),
        .cdata_o    (commit_data_o)
    );

    rtcwp_status #(.NEVT(NEVT), .SW(SW)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire_i    (fire),
        .evt_i     (evt_i),
        .clr_en_i  (clr_en),
        .clr_data_i(wdata_i[SW-1:0]),
        .ien_i     (ien),
        .flags_o   (flags),
        .irq_o     (irq_o)
    );

    rtcwp_shadow #(.DW(DW), .AW(AW), .SW(SW)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire_i     (fire),
        .fire_sel_i (hold_sel),
        .fire_data_i(hold_data),
        .psc_wr_i   (psc_wr),
        .psc_val_i  (wdata_i[0]),
        .ien_o      (ien),
        .alarm_o    (alarm),
        .swatch_o   (swatch),
        .psc_o      (psc)
    );

    always_comb begin
        stat_rd           = flags;
        stat_rd[BIT_PEND] = pend;
        case (addr_i)
            A_STAT:  rdata_o = DW'(stat_rd);
            A_IEN:   rdata_o = DW'(ien);
            A_TIME:  rdata_o = cnt_time_i;
            A_ALRM:  rdata_o = alarm;
            A_SWCH:  rdata_o = swatch;
            A_PSC:   rdata_o = DW'(psc);
            default: rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/rtcwp_chk.sv
module rtcwp_chk #(
    parameter int DW = 32,
    parameter int SW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pend_i,
    input logic          fire_i,
    input logic [DW-1:0] hold_i,
    input logic          cv_i,
    input logic          irq_i,
    input logic [SW-1:0] ien_i,
    input logic [SW-1:0] flags_i
);
    p_one_shot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cv_i |=> !cv_i);

    p_commit_clears_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cv_i |-> (!pend_i && flags_i[15]));

    p_done_on_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_i[15]) |-> cv_i);

    p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_i && !fire_i) |=> (pend_i && $stable(hold_i)));

    p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_i == '0) |-> !irq_i);
endmodule

bind rtc_wsync_port rtcwp_chk #(.DW(DW), .SW(rtcwp_pkg::STAT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .pend_i (pend),
    .fire_i (fire),
    .hold_i (hold_data),
    .cv_i   (commit_valid_o),
    .irq_i  (irq_o),
    .ien_i  (ien),
    .flags_i(flags)
);

// File: tb/tb_rtc_wsync_port.sv
module tb_rtc_wsync_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic        wr_i = 1'b0;
    logic [31:0] rdata_o;
    logic        irq_o;
    logic        tick_raw_i = 1'b0;
    logic        tick_sec_i = 1'b0;
    logic [6:0]  evt_i = '0;
    logic [31:0] cnt_time_i = '0;
    logic        commit_valid_o;
    logic [2:0]  commit_sel_o;
    logic [31:0] commit_data_o;

    int vectors = 0;
    int fails = 0;
    int commits_seen = 0;
    int pushed = 0;

    typedef struct {
        logic [2:0]  sel;
        logic [31:0] data;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    rtc_wsync_port dut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic expect_commit(logic [2:0] s, logic [31:0] d);
        exp_t e;
        e.sel = s;
        e.data = d;
        sb.push_back(e);
        pushed++;
    endtask

    always @(negedge clk) begin
        if (rst_n && commit_valid_o) begin
            commits_seen++;
            if (sb.size() == 0) begin
                vectors++;
                fails++;
                $display("FAIL R3: actual unexpected commit sel %0d data %h expected none",
                         commit_sel_o, commit_data_o);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk("R3 commit sel", 32'(commit_sel_o), 32'(e.sel));
                chk("R3 commit data", commit_data_o, e.data);
            end
        end
    end

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        addr_i = a; wdata_i = d; wr_i = 1'b1;
        @(negedge clk);
        wr_i = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] v);
        addr_i = a;
        #1;
        v = rdata_o;
    endtask

    task automatic tick_s();
        @(negedge clk); tick_sec_i = 1'b1;
        @(negedge clk); tick_sec_i = 1'b0;
    endtask

    task automatic tick_r();
        @(negedge clk); tick_raw_i = 1'b1;
        @(negedge clk); tick_raw_i = 1'b0;
    endtask

    task automatic pulse_evt(logic [6:0] m);
        @(negedge clk); evt_i = m;
        @(negedge clk); evt_i = '0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(0, v); chk("R1 status", v, 32'h0);
        rd(1, v); chk("R1 ien", v, 32'h0);
        rd(3, v); chk("R1 alarm", v, 32'h0);
        rd(4, v); chk("R1 stopwatch", v, 32'h0);
        rd(5, v); chk("R1 prescale", v, 32'h1);
        chk("R1 irq", 32'(irq_o), 32'h0);

        // R2 accept, R8 raw tick ignored, R4 dropped write
        wr(1, 32'h8001);
        rd(0, v); chk("R2 pending flag", v, 32'h4000);
        rd(1, v); chk("R2 old readback", v, 32'h0);
        tick_r();
        rd(0, v); chk("R8 raw tick ignored", v, 32'h4000);
        wr(1, 32'h1234);
        expect_commit(3'd1, 32'h8001);
        tick_s();
        rd(0, v); chk("R3 complete flag", v, 32'h8000);
        rd(1, v); chk("R4 second write dropped", v, 32'h8001);
        chk("R7 irq complete enabled", 32'(irq_o), 32'h1);
        wr(0, 32'h8000);
        rd(0, v); chk("R5 w1c done", v, 32'h0);
        chk("R7 irq cleared", 32'(irq_o), 32'h0);

        // R6 events, R7 masking
        pulse_evt(7'h01);
        rd(0, v); chk("R6 event bit0", v, 32'h1);
        chk("R7 irq event", 32'(irq_o), 32'h1);
        pulse_evt(7'h04);
        rd(0, v); chk("R6 event bit2", v, 32'h5);
        wr(0, 32'h1);
        rd(0, v); chk("R5 partial clear", v, 32'h4);
        chk("R7 disabled bit no irq", 32'(irq_o), 32'h0);
        wr(0, 32'h4);

        // R5 pending unaffected by status write
        wr(3, 32'hABC);
        wr(0, 32'hFFFF);
        rd(0, v); chk("R5 pend not cleared", v, 32'h4000);
        expect_commit(3'd3, 32'hABC);
        tick_s();
        rd(3, v); chk("R3 alarm committed", v, 32'hABC);
        wr(0, 32'h8000);

        // R8 prescale off
        wr(5, 32'h0);
        rd(5, v); chk("R8 prescale write", v, 32'h0);
        wr(4, 32'h5);
        tick_s();
        rd(0, v); chk("R8 sec tick ignored", v, 32'h4000);
        expect_commit(3'd4, 32'h5);
        tick_r();
        rd(4, v); chk("R8 raw tick commits", v, 32'h5);
        wr(0, 32'h8000);

        // R9 time path
        cnt_time_i = 32'h55;
        rd(2, v); chk("R9 time read", v, 32'h55);
        wr(2, 32'h777);
        expect_commit(3'd2, 32'h777);
        tick_r();
        rd(2, v); chk("R9 time still counter", v, 32'h55);
        wr(0, 32'h8000);

        // R10 unused addresses
        wr(6, 32'hFFFF);
        rd(0, v); chk("R10 no pending", v, 32'h0);
        rd(6, v); chk("R10 read 6", v, 32'h0);
        rd(7, v); chk("R10 read 7", v, 32'h0);

        // R5 set wins over same-edge clear
        @(negedge clk);
        evt_i = 7'h02; addr_i = 3'd0; wdata_i = 32'h2; wr_i = 1'b1;
        @(negedge clk);
        evt_i = '0; wr_i = 1'b0;
        rd(0, v); chk("R5 set wins", v, 32'h2);
        wr(0, 32'h2);

        // R3 tick on accepting edge does not commit
        @(negedge clk);
        addr_i = 3'd1; wdata_i = 32'h3; wr_i = 1'b1; tick_raw_i = 1'b1;
        @(negedge clk);
        wr_i = 1'b0; tick_raw_i = 1'b0;
        rd(0, v); chk("R3 no same-edge commit", v, 32'h4000);
        expect_commit(3'd1, 32'h3);
        tick_r();
        rd(1, v); chk("R3 ien committed", v, 32'h3);
        chk("R7 done not enabled", 32'(irq_o), 32'h0);

        repeat (2) @(negedge clk);
        chk("R3 all commits seen", 32'(commits_seen), 32'(pushed));
        chk("R3 scoreboard empty", 32'(sb.size()), 32'h0);
        summary();
        $finish;
    end
endmodule